// File: doc/BRIEF.md
# Burst Read Request Translator

This block sits behind a 32-bit memory-mapped slave read port and turns each read burst into a single outbound read request for a packet protocol that addresses 64-bit double words. A request carries the double-word address, a 4-bit read size code and a word pointer. Because the protocol supports only a few transfer sizes, the size code is rounded up to the next supported size. The block forwards only the words the master asked for and throws the surplus away.

Before a request is issued, the burst is checked for a legal length, for double-word alignment when it is longer than one word, and against a configurable word-address window. A burst that fails any of these checks produces no request. The master still receives the full number of beats, each flagged as an error. An error also sets a sticky status bit, which drives the interrupt line when its enable is set. One burst is handled at a time, and the port stalls the master until the burst has finished.

Top module: `rd_burst_xlate`

## Requirements
- R1: After the master's read is accepted, `req_valid` is high for exactly one cycle, in the cycle after acceptance, and only if the burst passes all checks. `req_dw_addr` equals the word address shifted right by one.
- R2: The size code and word pointer follow the burst length b.
  - b=1 gives code 1000, with `req_wdptr` equal to the inverse of address bit 0.
  - b=2 gives code 1011 with pointer 0.
  - For b from 3 to 64, let k=ceil(b/8). The code is 1100+floor((k-1)/2), and the pointer is 1 when k is even and 0 when k is odd. So 41..48 gives (1,1110), 49..56 gives (0,1111) and 57..64 gives (1,1111).
- R3: For a passing burst, the master receives exactly b beats with `s_readerror` low. They carry the first b response words in arrival order. The remaining response words of the rounded-up size are discarded.
- R4: A burst longer than one word whose word address has bit 0 set is failed. A single-word read at an odd address is legal.
- R5: A burst is failed when its length is 0 or above 64, when its start address is below `WIN_LO`, or when its last word lies above `WIN_HI`.
- R6: A failed burst returns max(b,1) beats. Each beat has `s_readdatavalid` and `s_readerror` high and `s_readdata` zero, and no request is issued.
- R7: A failed burst sets `irq_status`. Pulsing `ists_clr` clears it (write-one-to-clear).
- R8: `irq` is high exactly when both `irq_status` and `irq_enable` are high. `ien_wr` loads `irq_enable` from `ien_wdata`.
- R9: `s_waitrequest` is low when idle. It is high from the cycle after acceptance until the burst's last beat is delivered and every expected response word has arrived. No beat appears outside a burst.
- R10: After reset, `s_waitrequest`, `s_readdatavalid`, `s_readerror`, `req_valid`, `irq_status`, `irq_enable` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_address | input | ADDR_W | Slave word address |
| s_burstcount | input | BC_W | Burst length in words |
| s_read | input | 1 | Read request from master |
| s_waitrequest | output | 1 | Stall to master |
| s_readdata | output | DATA_W | Returned word |
| s_readdatavalid | output | 1 | Beat valid |
| s_readerror | output | 1 | Beat carries an error |
| req_valid | output | 1 | Outbound request strobe |
| req_dw_addr | output | ADDR_W-1 | Double-word address |
| req_rdsize | output | 4 | Read size code |
| req_wdptr | output | 1 | Word pointer |
| rsp_valid | input | 1 | Response word strobe |
| rsp_data | input | DATA_W | Response word |
| ien_wr | input | 1 | Interrupt enable write |
| ien_wdata | input | 1 | Interrupt enable value |
| ists_clr | input | 1 | Clear status (write one) |
| irq_status | output | 1 | Failed-mapping status bit |
| irq_enable | output | 1 | Interrupt enable bit |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker watches properties that hold on every cycle:
- error beats always come with valid beats and zero data;
- a request only follows an acceptance and carries a size code with its top bit set;
- the status bit rises only after an accepted read;
- no beat appears while the port is idle;
- the port is never released with a further beat pending.

Only the bench scenarios can show the rest: the exact size code for each burst length, the trimming of surplus response words and the data order, the beat count of failed bursts, the window edges, and the interplay of enable and clear. The bench sweeps every length from 0 to 65 and the alignment and window cases against values it computes itself.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_FAIL  = 2'd2
    } rbx_state_e;

    typedef struct packed {
        logic [3:0] rdsize;
        logic       wdptr;
    } rbx_code_t;

    // Size code and word pointer for a burst of 'beats' words.
    function automatic rbx_code_t size_code(input int unsigned beats, input logic addr_lsb);
        rbx_code_t   c;
        int unsigned k;
        if (beats <= 1) begin
            c.rdsize = 4'b1000;
            c.wdptr  = ~addr_lsb;
        end else if (beats == 2) begin
            c.rdsize = 4'b1011;
            c.wdptr  = 1'b0;
        end else begin
            k        = (beats + 7) / 8;
            c.rdsize = 4'(12 + (k - 1) / 2);
            c.wdptr  = ((k % 2) == 0);
        end
        return c;
    endfunction

    // Number of words the rounded-up request returns.
    function automatic int unsigned fetch_count(input int unsigned beats);
        if (beats <= 2)
            return (beats == 0) ? 1 : beats;
        return 8 * ((beats + 7) / 8);
    endfunction

endpackage

// File: rtl/rbx_decode.sv
module rbx_decode
    import rbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BC_W      = 7,
    parameter int MAX_BURST = 64,
    parameter int WIN_LO    = 32,
    parameter int WIN_HI    = 1023
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BC_W-1:0]   bcount,
    output logic              fail,
    output rbx_code_t         code,
    output logic [BC_W-1:0]   beats,
    output logic [BC_W-1:0]   fetch_words
);
    localparam logic [ADDR_W:0] LO_L = (ADDR_W+1)'(WIN_LO);
    localparam logic [ADDR_W:0] HI_L = (ADDR_W+1)'(WIN_HI);
    localparam logic [BC_W-1:0] MAX_L = BC_W'(MAX_BURST);

    logic            len_bad;
    logic            misalign;
    logic            below;
    logic            above;
    logic [ADDR_W:0] last_word;

    always_comb begin
        len_bad   = (bcount == '0) || (bcount > MAX_L);
        misalign  = (bcount > BC_W'(1)) && addr[0];
        last_word = {1'b0, addr} + (ADDR_W+1)'(bcount) - (ADDR_W+1)'(1);
        below     = ({1'b0, addr} < LO_L);
        above     = (last_word > HI_L);
        fail      = len_bad || misalign || below || above;
        beats       = (bcount == '0) ? BC_W'(1) : bcount;
        code        = size_code(int'(unsigned'(bcount)), addr[0]);
        fetch_words = BC_W'(fetch_count(int'(unsigned'(bcount))));
    end

endmodule

// File: rtl/rbx_beat_ctl.sv
module rbx_beat_ctl
    import rbx_pkg::*;
#(
    parameter int BC_W   = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fail,
    input  logic [BC_W-1:0]   beats,
    input  logic [BC_W-1:0]   fetch_words,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              busy,
    output logic              rd_valid,
    output logic              rd_error,
    output logic [DATA_W-1:0] rd_data
);
    rbx_state_e      state;
    logic [BC_W-1:0] left_beats;
    logic [BC_W-1:0] left_fetch;

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            left_beats <= '0;
            left_fetch <= '0;
            rd_valid   <= 1'b0;
            rd_error   <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid <= 1'b0;
            rd_error <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        left_beats <= beats;
                        left_fetch <= fetch_words;
                        state      <= fail ? ST_FAIL : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (rsp_valid) begin
                        left_fetch <= left_fetch - BC_W'(1);
                        if (left_beats != '0) begin
                            rd_valid   <= 1'b1;
                            rd_data    <= rsp_data;
                            left_beats <= left_beats - BC_W'(1);
                        end
                        if (left_fetch == BC_W'(1))
                            state <= ST_IDLE;
                    end
                end
                ST_FAIL: begin
                    rd_valid   <= 1'b1;
                    rd_error   <= 1'b1;
                    rd_data    <= '0;
                    left_beats <= left_beats - BC_W'(1);
                    if (left_beats == BC_W'(1))
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rbx_irq.sv
module rbx_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic en_wr,
    input  logic en_wdata,
    output logic status,
    output logic enable,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
            enable <= 1'b0;
        end else begin
            if (set)
                status <= 1'b1;
            else if (clr)
                status <= 1'b0;
            if (en_wr)
                enable <= en_wdata;
        end
    end

    assign irq = status & enable;

endmodule

// File: rtl/rd_burst_xlate.sv
module rd_burst_xlate
    import rbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 64,
    parameter int BC_W      = $clog2(MAX_BURST) + 1,
    parameter int WIN_LO    = 32,
    parameter int WIN_HI    = 1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_address,
    input  logic [BC_W-1:0]   s_burstcount,
    input  logic              s_read,
    output logic              s_waitrequest,
    output logic [DATA_W-1:0] s_readdata,
    output logic              s_readdatavalid,
    output logic              s_readerror,
    output logic              req_valid,
    output logic [ADDR_W-2:0] req_dw_addr,
    output logic [3:0]        req_rdsize,
    output logic              req_wdptr,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              ien_wr,
    input  logic              ien_wdata,
    input  logic              ists_clr,
    output logic              irq_status,
    output logic              irq_enable,
    output logic              irq
);
    logic            busy;
    logic            accept;
    logic            fail;
    rbx_code_t       code;
    logic [BC_W-1:0] beats;
    logic [BC_W-1:0] fetch_words;

    assign accept        = s_read && !busy;
    assign s_waitrequest = busy;

    rbx_decode #(
        .ADDR_W(ADDR_W), .BC_W(BC_W), .MAX_BURST(MAX_BURST),
        .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_decode (
        .addr(s_address), .bcount(s_burstcount), .fail(fail),
        .code(code), .beats(beats), .fetch_words(fetch_words)
    );

    rbx_beat_ctl #(.BC_W(BC_W), .DATA_W(DATA_W)) u_beat (
        .clk(clk), .rst(rst), .start(accept), .fail(fail),
        .beats(beats), .fetch_words(fetch_words),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .rd_valid(s_readdatavalid),
        .rd_error(s_readerror), .rd_data(s_readdata)
    );

    rbx_irq u_irq (
        .clk(clk), .rst(rst), .set(accept && fail), .clr(ists_clr),
        .en_wr(ien_wr), .en_wdata(ien_wdata),
        .status(irq_status), .enable(irq_enable), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid   <= 1'b0;
            req_dw_addr <= '0;
            req_rdsize  <= '0;
            req_wdptr   <= 1'b0;
        end else begin
            req_valid <= accept && !fail;
            if (accept && !fail) begin
                req_dw_addr <= s_address[ADDR_W-1:1];
                req_rdsize  <= code.rdsize;
                req_wdptr   <= code.wdptr;
            end
        end
    end

endmodule

// File: rtl/rbx_checker.sv
module rbx_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              s_read,
    input logic              s_waitrequest,
    input logic [DATA_W-1:0] s_readdata,
    input logic              s_readdatavalid,
    input logic              s_readerror,
    input logic              req_valid,
    input logic [3:0]        req_rdsize,
    input logic              irq_status
);
    a_r6_error_has_valid: assert property (@(posedge clk) disable iff (rst)
        s_readerror |-> s_readdatavalid);

    a_r6_error_zero_data: assert property (@(posedge clk) disable iff (rst)
        s_readerror |-> (s_readdata == '0));

    a_r1_req_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(s_read && !s_waitrequest));

    a_r2_code_msb: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_rdsize[3]);

    a_r7_status_after_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_status) |-> $past(s_read && !s_waitrequest));

    a_r9_beat_in_burst: assert property (@(posedge clk) disable iff (rst)
        s_readdatavalid |-> $past(s_waitrequest));

    a_r9_release_last: assert property (@(posedge clk) disable iff (rst)
        (s_readdatavalid && !s_waitrequest) |=> !s_readdatavalid);

endmodule

bind rd_burst_xlate rbx_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .s_read(s_read), .s_waitrequest(s_waitrequest),
    .s_readdata(s_readdata), .s_readdatavalid(s_readdatavalid),
    .s_readerror(s_readerror), .req_valid(req_valid),
    .req_rdsize(req_rdsize), .irq_status(irq_status)
);

// File: tb/tb_rd_burst_xlate.sv
module tb_rd_burst_xlate;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int BC_W   = 7;
    localparam int WIN_LO = 32;
    localparam int WIN_HI = 1023;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] s_address = '0;
    logic [BC_W-1:0]   s_burstcount = '0;
    logic              s_read = 1'b0;
    logic              s_waitrequest;
    logic [DATA_W-1:0] s_readdata;
    logic              s_readdatavalid;
    logic              s_readerror;
    logic              req_valid;
    logic [ADDR_W-2:0] req_dw_addr;
    logic [3:0]        req_rdsize;
    logic              req_wdptr;
    logic              rsp_valid = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              ien_wr = 1'b0;
    logic              ien_wdata = 1'b0;
    logic              ists_clr = 1'b0;
    logic              irq_status;
    logic              irq_enable;
    logic              irq;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rd_burst_xlate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(64),
                     .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int addr, input int bc, input int idx);
        return {8'hA5, 8'(addr), 8'(bc), 8'(idx)};
    endfunction

    // R2 expectations computed from the requirement text
    function automatic int exp_size(input int b);
        int k;
        if (b == 1) return 8;
        if (b == 2) return 11;
        k = (b + 7) / 8;
        return 12 + (k - 1) / 2;
    endfunction

    function automatic int exp_ptr(input int b, input int a);
        int k;
        if (b == 1) return (a % 2 == 0) ? 1 : 0;
        if (b == 2) return 0;
        k = (b + 7) / 8;
        return (k % 2 == 0) ? 1 : 0;
    endfunction

    function automatic int exp_fetch(input int b);
        if (b <= 2) return b;
        return 8 * ((b + 7) / 8);
    endfunction

    task automatic run_read(input int addr, input int bc, input bit exp_fail, input bit gaps);
        int beats_exp = (bc == 0) ? 1 : bc;
        int nfetch = exp_fail ? 0 : exp_fetch(bc);
        int reqs = 0, beats = 0, sent = 0, cyc = 0;
        bit rsp_on = 0;
        @(negedge clk);
        chk(s_waitrequest == 0, "R9", "idle waitrequest", s_waitrequest, 0);
        s_address = 12'(addr);
        s_burstcount = 7'(bc);
        s_read = 1'b1;
        @(negedge clk);
        s_read = 1'b0;
        while (cyc < 400) begin
            if (req_valid) begin
                reqs++;
                rsp_on = 1;
                chk(req_dw_addr == 11'(addr / 2), "R1", "dw addr", req_dw_addr, addr / 2);
                chk(req_rdsize == 4'(exp_size(bc)), "R2", "size code", req_rdsize, exp_size(bc));
                chk(req_wdptr == 1'(exp_ptr(bc, addr)), "R2", "word ptr", req_wdptr, exp_ptr(bc, addr));
            end
            if (s_readdatavalid) begin
                if (exp_fail) begin
                    chk(s_readerror == 1 && s_readdata == 0, "R6", "error beat", s_readdata, 0);
                end else begin
                    chk(s_readerror == 0, "R3", "no error", s_readerror, 0);
                    chk(s_readdata == word_of(addr, bc, beats), "R3", "beat data",
                        s_readdata, word_of(addr, bc, beats));
                end
                beats++;
            end
            if (!s_waitrequest) break;
            if (rsp_on && sent < nfetch && !(gaps && (cyc % 4 == 1))) begin
                rsp_valid = 1'b1;
                rsp_data = word_of(addr, bc, sent);
                sent++;
            end else begin
                rsp_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        rsp_valid = 1'b0;
        chk(reqs == (exp_fail ? 0 : 1), exp_fail ? "R6" : "R1", "request count", reqs, exp_fail ? 0 : 1);
        chk(beats == beats_exp, exp_fail ? "R6" : "R3", "beat count", beats, beats_exp);
        chk(sent == nfetch, "R3", "words consumed", sent, nfetch);
        if (exp_fail)
            chk(irq_status == 1, "R7", "status set", irq_status, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!s_readdatavalid && !req_valid, "R9", "quiet after burst", s_readdatavalid, 0);
        end
    endtask

    task automatic write_en(input bit v);
        @(negedge clk);
        ien_wr = 1'b1;
        ien_wdata = v;
        @(negedge clk);
        ien_wr = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk);
        ists_clr = 1'b1;
        @(negedge clk);
        ists_clr = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(!s_waitrequest && !s_readdatavalid && !s_readerror && !req_valid, "R10",
            "port idle after reset", {s_waitrequest, s_readdatavalid, s_readerror, req_valid}, 0);
        chk(!irq_status && !irq_enable && !irq, "R10", "irq regs after reset",
            {irq_status, irq_enable, irq}, 0);

        // R1 R2 R3: every legal length at an aligned address
        for (int b = 1; b <= 64; b++)
            run_read(64, b, 1'b0, (b % 3) == 0);
        chk(irq_status == 0, "R7", "status clear after legal reads", irq_status, 0);

        // R4 single word at odd address is legal, pointer inverted
        run_read(65, 1, 1'b0, 1'b0);
        run_read(64, 1, 1'b0, 1'b0);
        // R5 window edges that pass
        run_read(1020, 4, 1'b0, 1'b1);
        run_read(WIN_LO, 8, 1'b0, 1'b0);
        chk(irq_status == 0, "R5", "no status on legal edges", irq_status, 0);

        // R4 misaligned multi-word bursts fail, enable off so no irq
        for (int b = 2; b <= 5; b++) begin
            run_read(65, b, 1'b1, 1'b0);
            chk(irq == 0, "R8", "irq gated by enable", irq, 0);
        end
        run_read(127, 64, 1'b1, 1'b0);

        // R8 enabling raises irq from pending status
        write_en(1'b1);
        chk(irq_enable == 1 && irq == 1, "R8", "irq with enable", irq, 1);
        // R7 write-one-to-clear
        clear_status();
        chk(irq_status == 0 && irq == 0, "R7", "status cleared", irq_status, 0);

        // R5 window and length failures
        run_read(30, 2, 1'b1, 1'b0);
        chk(irq == 1, "R8", "irq on failure with enable", irq, 1);
        run_read(1020, 5, 1'b1, 1'b0);
        run_read(1022, 2, 1'b0, 1'b0);
        run_read(64, 0, 1'b1, 1'b0);
        run_read(64, 65, 1'b1, 1'b0);
        run_read(64, 100, 1'b1, 1'b0);
        write_en(1'b0);
        chk(irq == 0 && irq_status == 1, "R8", "irq drops with enable off", irq, 0);
        clear_status();
        chk(irq_status == 0, "R7", "final clear", irq_status, 0);

        done = 1;
        report();
    end

endmodule